// File: doc/BRIEF.md
# Serial Link Watchdog Timer

This block watches a serial control link and raises a communication-loss fault when the link goes quiet. The serial receiver gives it a one-cycle pulse each time a transfer arrives correctly framed. When a check code is enabled, that pulse is only given if the check code is also good. A slow timebase enable, nominally 1 kHz, advances an internal count. If the count reaches the period selected by a 3-bit configuration field before the next good transfer, the block sets a sticky timeout flag. That flag is meant to feed a status bit and to request the fault output and the alarm loop current.

The 3-bit field picks one of seven periods from a parameter table. Code 0 turns the watchdog off. With the default table, code 1 is about 43 ms and code 7 is about 5814 ms, counted in timebase ticks. A simulation can pass in a scaled-down table. The flag stays set until the status register is read, and reading it clears the flag. The count keeps running after an expiry, so a link that stays silent raises the flag again one period later.

Top module: `link_watchdog`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `timeout_flag` and `alarm_req` are 0.
- R2: While `period_code` is 0, the watchdog is disabled. No number of ticks sets the flag.
- R3: With a nonzero code held and no good transfer, the flag rises on the clock edge that samples the N-th `tick` after the last restart, where N is the period of that code. Cycles without `tick` do not advance the count.
- R4: A `frame_ok` pulse restarts the count from zero. It wins over a `tick` in the same cycle, so periodic transfers closer together than N ticks never set the flag.
- R5: Once set, the flag stays at 1 until a cycle with `fault_rd` high. It clears on the edge that samples that cycle.
- R6: After an expiry the count restarts and keeps running. With no transfer, the flag is set again N ticks later, whether or not it was read in between.
- R7: Any change of `period_code` restarts the count. The new period is then counted in full from zero.
- R8: Code c (1 to 7) selects the period held in bits [c*W-1:(c-1)*W] of the `PERIODS` parameter, where W is `CNT_W`. The default entries are 43, 97, 220, 497, 1124, 2542 and 5814 ticks.
- R9: If an expiry and `fault_rd` fall in the same cycle, the flag ends up set.
- R10: `alarm_req` equals `timeout_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_code | input | 3 | Period select from the configuration register, 0 = off |
| frame_ok | input | 1 | One-cycle pulse for each correctly framed (and check-code-valid) transfer |
| tick | input | 1 | Timebase enable, one cycle per period tick |
| fault_rd | input | 1 | One-cycle pulse when the status register is read |
| timeout_flag | output | 1 | Sticky link-timeout status bit |
| alarm_req | output | 1 | Request to drive the fault output and alarm current |

## Verification
The assertions assume that `tick`, `frame_ok` and `fault_rd` are synchronous to `clk`. They also assume that `period_code` changes only as a register write, and that every table entry is at least 1, so that the count limit is never zero. The stimulus drives every pulse for exactly one cycle, on a falling edge. The bench uses a table whose smallest entry is 3, so that the count can be walked up to the cycle just before an expiry. It then places reads, transfers and code changes exactly on that cycle.

// File: rtl/link_wdt_pkg.sv
package link_wdt_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] wdt_code_t;

  localparam wdt_code_t CODE_OFF = '0;
endpackage

// File: rtl/link_wdt_period_decode.sv
module link_wdt_period_decode
  import link_wdt_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter logic [NUM_CODES*CNT_W-1:0] PERIODS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  wdt_code_t        code,
  output logic [CNT_W-1:0] limit_q,
  output logic             en_q
);
  logic [CNT_W-1:0] hit [NUM_CODES];
  logic [CNT_W-1:0] limit_d;

  generate
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
      assign hit[g] = (code == wdt_code_t'(g + 1)) ? PERIODS[g*CNT_W +: CNT_W] : '0;
    end
  endgenerate

  always_comb begin
    limit_d = '0;
    for (int i = 0; i < NUM_CODES; i++) limit_d = limit_d | hit[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      en_q    <= 1'b0;
    end else begin
      limit_q <= limit_d;
      en_q    <= (code != CODE_OFF);
    end
  end

  // R8: an enabled period is never zero
  assert_limit_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (limit_q != '0));
endmodule

// File: rtl/link_wdt_tick_counter.sv
module link_wdt_tick_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == limit - CNT_W'(1));
  assign expire = tick && en && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick && en) begin
      cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end

  // R3: the count never passes the selected period
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < limit));
  // R4: a good transfer leaves the count at zero
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
  // R3: without a tick the count holds
  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/link_wdt_fault_latch.sv
module link_wdt_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic fault_rd,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (fault_rd) flag <= 1'b0;
  end

  // R3: flag only rises after an expiry
  assert_rise_on_expire_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(expire));
  // R5: flag only falls after a status read
  assert_fall_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(fault_rd));
  // R9: expiry wins over a same-cycle read
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (expire && fault_rd) |=> flag);
endmodule

// File: rtl/link_watchdog.sv
module link_watchdog
  import link_wdt_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter logic [NUM_CODES*CNT_W-1:0] PERIODS = {
    CNT_W'(5814), CNT_W'(2542), CNT_W'(1124), CNT_W'(497),
    CNT_W'(220),  CNT_W'(97),   CNT_W'(43)}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] period_code,
  input  logic       frame_ok,
  input  logic       tick,
  input  logic       fault_rd,
  output logic       timeout_flag,
  output logic       alarm_req
);
  wdt_code_t        code_q;
  logic             code_chg;
  logic [CNT_W-1:0] limit;
  logic             en;
  logic             restart;
  logic             expire;

  always_ff @(posedge clk) begin
    if (rst) code_q <= CODE_OFF;
    else     code_q <= period_code;
  end

  assign code_chg = (period_code != code_q);
  assign restart  = frame_ok || code_chg || !en;

  link_wdt_period_decode #(.CNT_W(CNT_W), .PERIODS(PERIODS)) u_decode (
    .clk(clk), .rst(rst), .code(period_code), .limit_q(limit), .en_q(en));

  link_wdt_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick), .en(en),
    .limit(limit), .expire(expire));

  link_wdt_fault_latch u_latch (
    .clk(clk), .rst(rst), .expire(expire), .fault_rd(fault_rd),
    .flag(timeout_flag));

  always_ff @(posedge clk) begin
    if (rst)           alarm_req <= 1'b0;
    else if (expire)   alarm_req <= 1'b1;
    else if (fault_rd) alarm_req <= 1'b0;
  end

  // R2: a disabled watchdog never expires
  assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (period_code == CODE_OFF) |-> !expire);
  // R7: a period write never expires in the same cycle
  assert_code_write_restart_R7: assert property (@(posedge clk) disable iff (rst)
    code_chg |-> !expire);
  // R10: alarm request follows the status flag
  assert_alarm_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    alarm_req == timeout_flag);
endmodule

// File: tb/link_watchdog_tb_top.sv
module link_watchdog_tb_top;
  localparam int CNT_W = 8;
  localparam logic [7*CNT_W-1:0] TB_PERIODS = {
    8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] period_code = 3'd0;
  logic       frame_ok = 1'b0;
  logic       tick = 1'b0;
  logic       fault_rd = 1'b0;
  logic       timeout_flag;
  logic       alarm_req;

  int checks = 0;
  int fails  = 0;

  bit    exp_q [$];
  string tag_q [$];

  // bench reference state
  int m_cnt = 0;
  bit m_flag = 0;
  int m_code_q = 0;

  always #5 clk = ~clk;

  link_watchdog #(.CNT_W(CNT_W), .PERIODS(TB_PERIODS)) dut_i (
    .clk(clk), .rst(rst), .period_code(period_code), .frame_ok(frame_ok),
    .tick(tick), .fault_rd(fault_rd), .timeout_flag(timeout_flag),
    .alarm_req(alarm_req));

  function automatic int period_of(int c);
    return c + 2; // R8: code c -> entry c of TB_PERIODS
  endfunction

  task automatic step(bit f, bit t, bit r, string tag);
    bit restart;
    bit exp_e;
    frame_ok = f; tick = t; fault_rd = r;
    @(posedge clk);
    restart = f || (int'(period_code) != m_code_q) || (period_code == 0);
    exp_e = 0;
    if (restart) m_cnt = 0;
    else if (t) begin
      if (m_cnt == period_of(period_code) - 1) begin m_cnt = 0; exp_e = 1; end
      else m_cnt++;
    end
    if (exp_e) m_flag = 1; else if (r) m_flag = 0;
    m_code_q = period_code;
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
    @(negedge clk);
    frame_ok = 0; tick = 0; fault_rd = 0;
  endtask

  task automatic set_code(int c, string tag);
    period_code = 3'(c);
    step(0, 0, 0, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      bit e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (timeout_flag !== e) begin
        fails++;
        $display("FAIL %s timeout_flag=%0b expected %0b", tg, timeout_flag, e);
      end
      checks++;
      if (alarm_req !== timeout_flag) begin
        fails++;
        $display("FAIL R10 alarm_req=%0b expected %0b", alarm_req, timeout_flag);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    period_code = 3'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (timeout_flag !== 0 || alarm_req !== 0) begin
      fails++;
      $display("FAIL R1 flag=%0b alarm=%0b expected 0 0", timeout_flag, alarm_req);
    end
    period_code = 3'd0;
    rst = 0;
    step(0, 1, 0, "R1");

    // R2: disabled watchdog ignores ticks
    for (int i = 0; i < 30; i++) step(0, 1, 0, "R2");

    // R3: code 1 expires after 3 ticks, gaps do not count
    set_code(1, "R7");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, "R3");
      step(0, 1, 0, "R3");
    end

    // R5: flag holds without read
    for (int i = 0; i < 2; i++) step(0, 0, 0, "R5");
    // R6: counter kept running, reaches period again while flag held
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R6");
    step(0, 0, 1, "R5");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R6");
    step(0, 0, 1, "R5");

    // R4: transfers every 2 ticks keep flag clear on code 3 (period 5)
    set_code(3, "R7");
    for (int k = 0; k < 10; k++) begin
      step(0, 1, 0, "R4");
      step(0, 1, 0, "R4");
      step(1, 0, 0, "R4");
    end
    // R4: transfer and tick in the same cycle at the last count
    while (m_cnt != period_of(3) - 1) step(0, 1, 0, "R4");
    step(1, 1, 0, "R4");
    step(0, 1, 0, "R4");

    // R7: code write at the last count restarts the full new period
    while (m_cnt != period_of(3) - 1) step(0, 1, 0, "R7");
    period_code = 3'd4;
    step(0, 1, 0, "R7");
    for (int i = 0; i < period_of(4); i++) step(0, 1, 0, "R7");
    step(0, 0, 1, "R5");

    // R9: expiry and read in the same cycle
    while (m_cnt != period_of(4) - 1) step(0, 1, 0, "R9");
    step(0, 1, 1, "R9");
    step(0, 0, 1, "R5");

    // R8: each table entry
    for (int c = 1; c <= 7; c++) begin
      set_code(c, "R8");
      for (int i = 0; i < period_of(c) + 1; i++) step(0, 1, 0, "R8");
      step(0, 0, 1, "R8");
    end

    // R2: disabling holds flag clear
    set_code(0, "R2");
    for (int i = 0; i < 20; i++) step(0, 1, 0, "R2");

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule